// File: doc/BRIEF.md
# Split-Capable 8-bit Auto-Reload Timer

This block is an 8-bit timer/counter built from two byte registers, a low byte and a high byte. In its auto-reload mode the low byte counts upward. Each time it steps past its all-ones value, it takes on whatever the high byte currently holds, and it raises overflow flag A. The high byte therefore sets the period, and software can retune that period at any time without stopping the count. The low byte counts either a fixed time base, which is the clock divided by a parameter (6 by default), or falling edges on an external count pin that are synchronised to the clock. It can also be gated by an external level.

In split mode the unit becomes two free-running 8-bit timers that both wrap to zero. The low byte keeps its own source select, gate and run bit, and it still drives flag A. The high byte always counts the divided time base. It starts and stops on a second run bit, and it raises flag B, the flag that normally belongs to a second timer channel. Each flag is an interrupt request and clears on its acknowledge input. A write port lets software load either byte.

Top module: `tmr_split_unit`

## Requirements
- R1: While reset is high and on the first cycle after it, `low_q`, `high_q`, `flag_a` and `flag_b` are all 0.
- R2: With `ct_sel`=0 and the low byte enabled, the low byte steps once every 6 clocks (DIV). The first step comes on the 6th rising edge after reset is released.
- R3: With `ct_sel`=1, the low byte steps once for each high-to-low transition of `cnt_pin`. The new value becomes visible on the third rising edge after the transition.
- R4: The low byte steps only when `run_a`=1 and either `gate_en`=0 or `gate_pin`=1. Otherwise it holds its value.
- R5: In mode 2 (`mode`=2'b10), a step from 0xFF loads the low byte with the present value of `high_q` and sets `flag_a`. In this mode `high_q` changes only through writes.
- R6: A write to the high byte (`wr_sel`=1) is accepted in any cycle, and the next reload uses the new value.
- R7: In mode 3 (`mode`=2'b11), a step of the low byte from 0xFF gives 0x00 and sets `flag_a`.
- R8: In mode 3 the high byte steps once every 6 clocks while `run_b`=1, whatever the values of `ct_sel`, `gate_en` and `gate_pin`. Its step from 0xFF gives 0x00 and sets `flag_b`.
- R9: `ack_a` or `ack_b` clears its flag on the next cycle. If an overflow on the same cycle would set that flag, the flag stays 1.
- R10: A write to the low byte (`wr_sel`=0) on the overflow cycle wins over the reload or wrap, and `flag_a` is still set.
- R11: In modes 0 and 1, neither byte steps and no flag is set. Writes still load the bytes.
- R12: `flag_b` is never set while the mode is 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 2'b10 auto-reload, 2'b11 split, other values hold |
| ct_sel | input | 1 | Low-byte source: 0 divided clock, 1 count pin |
| gate_en | input | 1 | 1 makes the low byte depend on `gate_pin` |
| run_a | input | 1 | Run bit for the low byte |
| run_b | input | 1 | Run bit for the high byte in split mode |
| cnt_pin | input | 1 | External count input, asynchronous |
| gate_pin | input | 1 | External gate level |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the low byte, 1 selects the high byte |
| wr_data | input | 8 | Write data |
| ack_a | input | 1 | Acknowledge for `flag_a` |
| ack_b | input | 1 | Acknowledge for `flag_b` |
| low_q | output | 8 | Low byte value |
| high_q | output | 8 | High byte value |
| flag_a | output | 1 | Low-byte overflow request |
| flag_b | output | 1 | High-byte overflow request (split mode) |

## Verification
The bench lands a software write to the low byte on the exact overflow edge. A design that lets the reload win here loses the written value. It also lands an acknowledge on a fresh overflow, which a design that clears first would drop. In split mode the bench holds the gate closed and selects pin counting, so a high byte that wrongly obeys those controls stalls and never raises `flag_b`. It also retunes the high byte in the middle of a run. A design that latches the reload value would then reload a stale period. It also steps the mode through 2 and 0, where a leaking split path would set `flag_b` or move a byte that should hold.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD0  = 2'b00,
    MODE_HOLD1  = 2'b01,
    MODE_RELOAD = 2'b10,
    MODE_SPLIT  = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2: time-base ticks are never back to back
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (DIV > 1 && tick) |=> !tick);
endmodule

// File: rtl/tmr_fall_sync.sv
module tmr_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh[0] <= 1'b0;
    else     sh[0] <= pin;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sh[i] <= 1'b0;
      else     sh[i] <= sh[i-1];
    end
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/tmr_byte_cnt.sv
module tmr_byte_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q,
  output logic         ovf
);
  assign ovf = inc & (q == {W{1'b1}});

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (wr)  q <= wdata;
    else if (inc) q <= ovf ? load_val : q + 1'b1;
  end

  // R4: without a step or a write the byte holds
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr) |=> $stable(q));
  // R10: a write always lands, whatever the counter does
  p_write_wins_r10: assert property (@(posedge clk) disable iff (rst)
    wr |=> (q == $past(wdata)));
endmodule

// File: rtl/tmr_irq_flag.sv
module tmr_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set | (flag & ~ack);
  end

  // R9: acknowledge clears when nothing new arrives
  p_ack_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && !set) |=> !flag);
  // R9: a coincident event is kept
  p_set_kept_r9: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);
endmodule

// File: rtl/tmr_split_unit.sv
module tmr_split_unit #(
  parameter int W    = 8,
  parameter int DIV  = 6,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [1:0]   mode,
  input  logic         ct_sel,
  input  logic         gate_en,
  input  logic         run_a,
  input  logic         run_b,
  input  logic         cnt_pin,
  input  logic         gate_pin,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ack_a,
  input  logic         ack_b,
  output logic [W-1:0] low_q,
  output logic [W-1:0] high_q,
  output logic         flag_a,
  output logic         flag_b
);
  import tmr_pkg::*;

  tmr_mode_e md;
  logic tick, pin_fall;
  logic split_m, reload_m;
  logic gate_ok, src_lo, inc_lo, inc_hi;
  logic wr_lo, wr_hi, ovf_lo, ovf_hi;
  logic [W-1:0] lo_load;

  assign md       = tmr_mode_e'(mode);
  assign split_m  = (md == MODE_SPLIT);
  assign reload_m = (md == MODE_RELOAD);

  tmr_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  tmr_fall_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .pin(cnt_pin), .fall(pin_fall)
  );

  assign gate_ok = ~gate_en | gate_pin;
  assign src_lo  = ct_sel ? pin_fall : tick;
  assign inc_lo  = (split_m | reload_m) & run_a & gate_ok & src_lo;
  assign inc_hi  = split_m & run_b & tick;
  assign wr_lo   = wr_en & ~wr_sel;
  assign wr_hi   = wr_en & wr_sel;
  assign lo_load = split_m ? '0 : high_q;

  tmr_byte_cnt #(.W(W)) u_lo (
    .clk(clk), .rst(rst), .inc(inc_lo), .wr(wr_lo), .wdata(wr_data),
    .load_val(lo_load), .q(low_q), .ovf(ovf_lo)
  );

  tmr_byte_cnt #(.W(W)) u_hi (
    .clk(clk), .rst(rst), .inc(inc_hi), .wr(wr_hi), .wdata(wr_data),
    .load_val({W{1'b0}}), .q(high_q), .ovf(ovf_hi)
  );

  tmr_irq_flag u_flag_a (
    .clk(clk), .rst(rst), .set(ovf_lo), .ack(ack_a), .flag(flag_a)
  );

  tmr_irq_flag u_flag_b (
    .clk(clk), .rst(rst), .set(ovf_hi), .ack(ack_b), .flag(flag_b)
  );

  // R5: reload takes the high byte as it stood on the overflow edge
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    (reload_m && inc_lo && low_q == {W{1'b1}} && !wr_lo)
      |=> (low_q == $past(high_q)));
  // R5: the high byte is left alone by the counting path in mode 2
  p_hi_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    (reload_m && !wr_hi) |=> $stable(high_q));
  // R7: split-mode wrap of the low byte
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (split_m && inc_lo && low_q == {W{1'b1}} && !wr_lo) |=> (low_q == '0));
  // R11: hold modes move nothing but writes
  p_hold_mode_r11: assert property (@(posedge clk) disable iff (rst)
    (!split_m && !reload_m && !wr_en) |=> ($stable(low_q) && $stable(high_q)));
  // R12: flag B cannot rise in mode 2
  p_no_b_r12: assert property (@(posedge clk) disable iff (rst)
    (reload_m && !flag_b) |=> !flag_b);
endmodule

// File: tb/tmr_split_unit_bench.sv
module tmr_split_unit_bench;
  localparam int DIV = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic ct_sel = 0, gate_en = 0, run_a = 0, run_b = 0;
  logic cnt_pin = 1, gate_pin = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 8'h00;
  logic ack_a = 0, ack_b = 0;
  logic [7:0] low_q, high_q;
  logic flag_a, flag_b;

  int checks = 0, errors = 0, cycles = 0;
  string tag = "R1";
  bit done = 0;

  // reference state
  int m_p, m_lo, m_hi, m_fa, m_fb, m_s1, m_s2, m_s3;

  always #4 clk = ~clk;

  tmr_split_unit u_tmr_split_unit (
    .clk(clk), .rst(rst), .mode(mode), .ct_sel(ct_sel), .gate_en(gate_en),
    .run_a(run_a), .run_b(run_b), .cnt_pin(cnt_pin), .gate_pin(gate_pin),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .ack_a(ack_a),
    .ack_b(ack_b), .low_q(low_q), .high_q(high_q), .flag_a(flag_a),
    .flag_b(flag_b)
  );

  always @(posedge clk) begin
    int tk, fl, il, ih, ol, oh, oldh;
    cycles++;
    if (rst) begin
      m_p = 0; m_lo = 0; m_hi = 0; m_fa = 0; m_fb = 0;
      m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      tk = (m_p == DIV - 1);
      fl = (m_s3 == 1 && m_s2 == 0);
      m_p = tk ? 0 : m_p + 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin;
      il = (mode >= 2) && run_a && (!gate_en || gate_pin) && (ct_sel ? fl : tk);
      ih = (mode == 3) && run_b && tk;
      ol = il && (m_lo == 255);
      oh = ih && (m_hi == 255);
      oldh = m_hi;
      if (wr_en && wr_sel) m_hi = wr_data;
      else if (ih) m_hi = (m_hi + 1) % 256;
      if (wr_en && !wr_sel) m_lo = wr_data;
      else if (il) m_lo = ol ? ((mode == 3) ? 0 : oldh) : m_lo + 1;
      m_fa = (ol || (m_fa && !ack_a)) ? 1 : 0;
      m_fb = (oh || (m_fb && !ack_b)) ? 1 : 0;
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d (cycle %0d)", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("low_q", low_q, m_lo);
      chk("high_q", high_q, m_hi);
      chk("flag_a", flag_a, m_fa);
      chk("flag_b", flag_b, m_fb);
    end
  end

  always @(negedge clk) begin
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit sel, input int d);
    @(negedge clk);
    wr_en = 1; wr_sel = sel; wr_data = 8'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  // stops at the negedge before an edge that ticks while the low byte is 0xFF
  task automatic wait_lo_ovf();
    @(negedge clk);
    while (!(m_p == DIV - 1 && m_lo == 255)) @(negedge clk);
  endtask

  initial begin
    step(3);
    tag = "R1";
    chk("low_q reset", low_q, 0);
    chk("high_q reset", high_q, 0);
    chk("flag_a reset", flag_a, 0);
    chk("flag_b reset", flag_b, 0);
    rst = 0;

    // R2 / R5: timer source, auto-reload
    tag = "R2"; mode = 2'b10; run_a = 1;
    step(30);
    tag = "R5";
    wr(1, 8'hF0); wr(0, 8'hFA);
    step(120);
    ack_a = 1; step(1); ack_a = 0;

    // R6: retune the period mid run
    tag = "R6";
    wr(1, 8'h80);
    step(60);

    // R4: gating
    tag = "R4"; gate_en = 1; gate_pin = 0;
    step(40);
    gate_pin = 1; step(30);
    run_a = 0; step(30);
    run_a = 1; gate_en = 0;

    // R10: write on the overflow edge
    tag = "R10";
    wr(0, 8'hFF);
    wait_lo_ovf();
    wr_en = 1; wr_sel = 0; wr_data = 8'h33;
    step(1); wr_en = 0;
    step(3);

    // R9: acknowledge coincident with overflow keeps the flag
    tag = "R9";
    wr(0, 8'hFF);
    wait_lo_ovf();
    ack_a = 1; step(1); ack_a = 0;
    step(3);
    ack_a = 1; step(1); ack_a = 0;
    step(3);

    // R3: pin counting
    tag = "R3"; ct_sel = 1;
    wr(0, 8'hFC);
    for (int i = 0; i < 10; i++) begin
      cnt_pin = 0; step(3);
      cnt_pin = 1; step(4);
    end
    step(5);

    // R12: second run bit set in mode 2
    tag = "R12"; run_b = 1; ct_sel = 0;
    step(200);

    // R8: split mode, high byte ignores source select and gate
    tag = "R8"; mode = 2'b11; ct_sel = 1; gate_en = 1; gate_pin = 0;
    wr(1, 8'hFA); wr(0, 8'h10);
    step(60);
    ack_b = 1; step(1); ack_b = 0;
    step(20);

    // R7: split mode, low byte wraps
    tag = "R7"; ct_sel = 0; gate_en = 0; ack_a = 1; step(1); ack_a = 0;
    wr(0, 8'hFD);
    step(40);
    run_b = 0; step(20);

    // R11: hold modes
    tag = "R11"; mode = 2'b00; run_b = 1;
    step(40);
    wr(0, 8'h44); wr(1, 8'h55);
    mode = 2'b01; step(40);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule